// File: doc/BRIEF.md
# AXI Pending Transaction Limiter

This block sits on the address and response handshakes between an AXI manager and a subordinate. It keeps a running count of read and write transactions that have been accepted downstream and have not yet completed. When a configured ceiling is reached, it holds back new read or write address handshakes. A read counts from its address handshake until the final data beat (the one flagged last) completes its handshake. A write counts from its address handshake until the write response handshake completes.

Three ceilings are available, each 6 bits wide and driven as a static configuration input. One applies to reads, one to writes, and one to reads and writes together. Setting a ceiling to zero removes that ceiling. It does not block traffic. The read data and write response handshakes pass straight through. The block never reorders traffic, splits bursts or inspects protocol.

A request that has been offered downstream stays asserted until it is accepted. While it waits, it keeps its slot under the combined ceiling. When a new read and a new write arrive together and only one combined slot is left, the read goes first.

Top module: `apl_limiter`

## Requirements
- R1: After reset no transaction is pending, so with nonzero ceilings the first read and the first write address are each forwarded and accepted at once.
- R2: With a nonzero read ceiling N, at most N reads are pending. Once N are pending, `m_arvalid` and `s_arready` stay low while `s_arvalid` is high.
- R3: With a nonzero write ceiling N, at most N writes are pending. Once N are pending, `m_awvalid` and `s_awready` stay low while `s_awvalid` is high.
- R4: With a nonzero combined ceiling N, the pending reads plus pending writes never exceed N. A request offered downstream and not yet accepted counts against N.
- R5: A ceiling of zero places no limit on its count. With all three at zero, 40 back-to-back reads are each accepted in the cycle they are offered.
- R6: A read retires only on an R handshake with `m_rlast` high. An R handshake with `m_rlast` low leaves the pending read count unchanged.
- R7: A write retires on a B handshake (`m_bvalid` and `s_bready` both high).
- R8: Once `m_arvalid` or `m_awvalid` is high without its ready, it stays high in the next cycle. This holds even if the other channel is waiting for a slot.
- R9: When a new read and a new write are both eligible in one cycle and only one slot remains under the combined ceiling, the read is forwarded and the write waits.
- R10: A new read handshake and a read retirement in the same cycle leave the pending read count unchanged.
- R11: The R and B channels pass through combinationally: `s_rvalid`=`m_rvalid`, `s_rlast`=`m_rlast`, `m_rready`=`s_rready`, `s_bvalid`=`m_bvalid`, `m_bready`=`s_bready`. A downstream valid is never raised without the matching upstream valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_max | input | 6 | Pending read ceiling, 0 = none |
| cfg_wr_max | input | 6 | Pending write ceiling, 0 = none |
| cfg_all_max | input | 6 | Combined pending ceiling, 0 = none |
| s_arvalid | input | 1 | Read address valid from manager |
| s_arready | output | 1 | Read address ready to manager |
| m_arvalid | output | 1 | Read address valid to subordinate |
| m_arready | input | 1 | Read address ready from subordinate |
| s_awvalid | input | 1 | Write address valid from manager |
| s_awready | output | 1 | Write address ready to manager |
| m_awvalid | output | 1 | Write address valid to subordinate |
| m_awready | input | 1 | Write address ready from subordinate |
| m_rvalid | input | 1 | Read data valid from subordinate |
| m_rlast | input | 1 | Final read beat flag from subordinate |
| m_rready | output | 1 | Read data ready to subordinate |
| s_rvalid | output | 1 | Read data valid to manager |
| s_rlast | output | 1 | Final read beat flag to manager |
| s_rready | input | 1 | Read data ready from manager |
| m_bvalid | input | 1 | Write response valid from subordinate |
| m_bready | output | 1 | Write response ready to subordinate |
| s_bvalid | output | 1 | Write response valid to manager |
| s_bready | input | 1 | Write response ready from manager |

## Verification
The assertions rely on several assumptions about the inputs. The manager holds `s_arvalid` and `s_awvalid` until they are accepted. The subordinate never returns a final read beat or a write response without a pending transaction. The ceilings change only while nothing is pending. With a ceiling at zero, fewer than 255 transactions of one kind are outstanding. The directed stimulus keeps each valid raised until its handshake, retires only transactions it has issued, reprograms ceilings between scenarios once everything has drained, and keeps the unlimited burst at 40.

// File: rtl/apl_pkg.sv
`timescale 1ns/1ps
package apl_pkg;
    // default widths of a ceiling field and of a pending counter
    parameter int unsigned APL_LIM_W = 6;
    parameter int unsigned APL_CNT_W = 8;

    // channel index used for per-channel arrays
    typedef enum int unsigned {
        CH_RD = 0,
        CH_WR = 1
    } apl_ch_e;

    localparam int unsigned APL_NUM_CH = 2;
endpackage

// File: rtl/apl_cnt_next.sv
`timescale 1ns/1ps
// Next value of one pending counter; issue and retire may coincide.
module apl_cnt_next #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cur,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] nxt
);
    always_comb begin
        unique case ({inc, dec})
            2'b10:   nxt = cur + W'(1);
            2'b01:   nxt = cur - W'(1);
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/apl_admit.sv
`timescale 1ns/1ps
// Admission decision for both address channels, read served first.
module apl_admit #(
    parameter int unsigned LIM_W = 6,
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt_rd,
    input  logic [CNT_W-1:0] cnt_wr,
    input  logic             hold_rd,
    input  logic             hold_wr,
    input  logic [LIM_W-1:0] max_rd,
    input  logic [LIM_W-1:0] max_wr,
    input  logic [LIM_W-1:0] max_all,
    input  logic             req_rd,
    output logic             ok_rd,
    output logic             ok_wr
);
    localparam int unsigned SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] used;
    logic [SUM_W-1:0] used_after_rd;
    logic             room_rd;
    logic             room_wr;
    logic             room_all_rd;
    logic             room_all_wr;
    logic             take_rd;

    always_comb begin
        used = SUM_W'(cnt_rd) + SUM_W'(cnt_wr)
             + SUM_W'(hold_rd) + SUM_W'(hold_wr);

        room_rd     = (max_rd == '0) || (cnt_rd < CNT_W'(max_rd));
        room_wr     = (max_wr == '0) || (cnt_wr < CNT_W'(max_wr));
        room_all_rd = (max_all == '0) || (used < SUM_W'(max_all));

        // a new read that will be forwarded this cycle claims a slot first
        take_rd       = req_rd && !hold_rd && room_rd && room_all_rd;
        used_after_rd = used + SUM_W'(take_rd);
        room_all_wr   = (max_all == '0) || (used_after_rd < SUM_W'(max_all));

        ok_rd = hold_rd || (room_rd && room_all_rd);
        ok_wr = hold_wr || (room_wr && room_all_wr);
    end
endmodule

// File: rtl/apl_limiter.sv
`timescale 1ns/1ps
module apl_limiter
    import apl_pkg::*;
#(
    parameter int unsigned LIM_W = APL_LIM_W,
    parameter int unsigned CNT_W = APL_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LIM_W-1:0] cfg_rd_max,
    input  logic [LIM_W-1:0] cfg_wr_max,
    input  logic [LIM_W-1:0] cfg_all_max,
    input  logic             s_arvalid,
    output logic             s_arready,
    output logic             m_arvalid,
    input  logic             m_arready,
    input  logic             s_awvalid,
    output logic             s_awready,
    output logic             m_awvalid,
    input  logic             m_awready,
    input  logic             m_rvalid,
    input  logic             m_rlast,
    output logic             m_rready,
    output logic             s_rvalid,
    output logic             s_rlast,
    input  logic             s_rready,
    input  logic             m_bvalid,
    output logic             m_bready,
    output logic             s_bvalid,
    input  logic             s_bready
);
    typedef struct packed {
        logic [APL_NUM_CH-1:0][CNT_W-1:0] cnt;
        logic [APL_NUM_CH-1:0]            hold;
    } state_t;

    state_t state_d, state_q;

    logic                             ok_rd, ok_wr;
    logic [APL_NUM_CH-1:0]            issue, retire;
    logic [APL_NUM_CH-1:0][CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0]                 cnt_rd_w, cnt_wr_w;

    assign cnt_rd_w = state_q.cnt[CH_RD];
    assign cnt_wr_w = state_q.cnt[CH_WR];

    apl_admit #(.LIM_W(LIM_W), .CNT_W(CNT_W)) admit_i (
        .cnt_rd  (cnt_rd_w),
        .cnt_wr  (cnt_wr_w),
        .hold_rd (state_q.hold[CH_RD]),
        .hold_wr (state_q.hold[CH_WR]),
        .max_rd  (cfg_rd_max),
        .max_wr  (cfg_wr_max),
        .max_all (cfg_all_max),
        .req_rd  (s_arvalid),
        .ok_rd   (ok_rd),
        .ok_wr   (ok_wr)
    );

    // address gating and response pass-through
    always_comb begin
        m_arvalid = s_arvalid && ok_rd;
        s_arready = m_arready && ok_rd;
        m_awvalid = s_awvalid && ok_wr;
        s_awready = m_awready && ok_wr;

        s_rvalid  = m_rvalid;
        s_rlast   = m_rlast;
        m_rready  = s_rready;
        s_bvalid  = m_bvalid;
        m_bready  = s_bready;

        issue[CH_RD]  = m_arvalid && m_arready;
        issue[CH_WR]  = m_awvalid && m_awready;
        retire[CH_RD] = m_rvalid && s_rready && m_rlast;
        retire[CH_WR] = m_bvalid && s_bready;
    end

    for (genvar ch = 0; ch < APL_NUM_CH; ch++) begin : g_ch
        apl_cnt_next #(.W(CNT_W)) cnt_i (
            .cur (state_q.cnt[ch]),
            .inc (issue[ch]),
            .dec (retire[ch]),
            .nxt (cnt_nxt[ch])
        );
    end

    always_comb begin
        state_d            = state_q;
        state_d.cnt        = cnt_nxt;
        state_d.hold[CH_RD] = m_arvalid && !m_arready;
        state_d.hold[CH_WR] = m_awvalid && !m_awready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/apl_checker.sv
`timescale 1ns/1ps
module apl_checker #(
    parameter int unsigned LIM_W = 6,
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LIM_W-1:0] cfg_rd_max,
    input logic [LIM_W-1:0] cfg_wr_max,
    input logic [LIM_W-1:0] cfg_all_max,
    input logic [CNT_W-1:0] cnt_rd,
    input logic [CNT_W-1:0] cnt_wr,
    input logic             hold_rd,
    input logic             hold_wr,
    input logic             s_arvalid,
    input logic             s_awvalid,
    input logic             m_arvalid,
    input logic             m_arready,
    input logic             m_awvalid,
    input logic             m_awready,
    input logic             m_rvalid,
    input logic             m_rlast,
    input logic             s_rready,
    input logic             m_bvalid,
    input logic             s_bready
);
    localparam int unsigned SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] both;
    assign both = SUM_W'(cnt_rd) + SUM_W'(cnt_wr);

    assert_rd_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_max != '0) |-> (cnt_rd <= CNT_W'(cfg_rd_max)));

    assert_wr_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_max != '0) |-> (cnt_wr <= CNT_W'(cfg_wr_max)));

    assert_all_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_all_max != '0) |->
        (both + SUM_W'(hold_rd) + SUM_W'(hold_wr) <= SUM_W'(cfg_all_max)));

    // retirement never arrives with nothing pending (input contract)
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rvalid && s_rready && m_rlast) |-> (cnt_rd != '0));

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bvalid && s_bready) |-> (cnt_wr != '0));

    assert_ar_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> m_arvalid);

    assert_aw_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> m_awvalid);

    assert_rd_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && m_awvalid && !hold_rd && !hold_wr && cfg_all_max != '0)
        |-> (both + SUM_W'(2) <= SUM_W'(cfg_all_max)));

    assert_ar_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> s_arvalid);

    assert_aw_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> s_awvalid);
endmodule

bind apl_limiter apl_checker #(.LIM_W(LIM_W), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rd_max  (cfg_rd_max),
    .cfg_wr_max  (cfg_wr_max),
    .cfg_all_max (cfg_all_max),
    .cnt_rd      (cnt_rd_w),
    .cnt_wr      (cnt_wr_w),
    .hold_rd     (state_q.hold[0]),
    .hold_wr     (state_q.hold[1]),
    .s_arvalid   (s_arvalid),
    .s_awvalid   (s_awvalid),
    .m_arvalid   (m_arvalid),
    .m_arready   (m_arready),
    .m_awvalid   (m_awvalid),
    .m_awready   (m_awready),
    .m_rvalid    (m_rvalid),
    .m_rlast     (m_rlast),
    .s_rready    (s_rready),
    .m_bvalid    (m_bvalid),
    .s_bready    (s_bready)
);

// File: tb/apl_limiter_tb.sv
`timescale 1ns/1ps
module apl_limiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_rd_max = '0, cfg_wr_max = '0, cfg_all_max = '0;
    logic s_arvalid = 0, m_arready = 0, s_awvalid = 0, m_awready = 0;
    logic m_rvalid = 0, m_rlast = 0, s_rready = 0, m_bvalid = 0, s_bready = 0;
    logic s_arready, m_arvalid, s_awready, m_awvalid;
    logic m_rready, s_rvalid, s_rlast, m_bready, s_bvalid;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    apl_limiter dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_rd_max(cfg_rd_max), .cfg_wr_max(cfg_wr_max), .cfg_all_max(cfg_all_max),
        .s_arvalid(s_arvalid), .s_arready(s_arready),
        .m_arvalid(m_arvalid), .m_arready(m_arready),
        .s_awvalid(s_awvalid), .s_awready(s_awready),
        .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_rvalid(m_rvalid), .m_rlast(m_rlast), .m_rready(m_rready),
        .s_rvalid(s_rvalid), .s_rlast(s_rlast), .s_rready(s_rready),
        .m_bvalid(m_bvalid), .m_bready(m_bready),
        .s_bvalid(s_bvalid), .s_bready(s_bready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [5:0] r, input logic [5:0] w, input logic [5:0] a);
        @(negedge clk);
        cfg_rd_max = r; cfg_wr_max = w; cfg_all_max = a;
    endtask

    // offer one read address with the subordinate ready
    task automatic try_ar(input string req, input bit exp_ok);
        @(negedge clk);
        s_arvalid = 1; m_arready = 1;
        #1;
        chk(req, {m_arvalid, s_arready}, exp_ok ? 2 'b11 : 2'b00);
        @(posedge clk); #1;
        s_arvalid = 0; m_arready = 0;
    endtask

    task automatic try_aw(input string req, input bit exp_ok);
        @(negedge clk);
        s_awvalid = 1; m_awready = 1;
        #1;
        chk(req, {m_awvalid, s_awready}, exp_ok ? 2'b11 : 2'b00);
        @(posedge clk); #1;
        s_awvalid = 0; m_awready = 0;
    endtask

    task automatic rbeat(input bit last);
        @(negedge clk);
        m_rvalid = 1; s_rready = 1; m_rlast = last;
        @(posedge clk); #1;
        m_rvalid = 0; s_rready = 0; m_rlast = 0;
    endtask

    task automatic bresp();
        @(negedge clk);
        m_bvalid = 1; s_bready = 1;
        @(posedge clk); #1;
        m_bvalid = 0; s_bready = 0;
    endtask

    task automatic t_reset();
        set_cfg(6'd1, 6'd1, 6'd0);
        @(negedge clk); #1;
        chk("R1 idle arvalid", m_arvalid, 0);
        chk("R1 idle awvalid", m_awvalid, 0);
        try_ar("R1 first read", 1);
        try_aw("R1 first write", 1);
        rbeat(1);
        bresp();
    endtask

    task automatic t_read_cap();
        set_cfg(6'd2, 6'd0, 6'd0);
        try_ar("R2 read 1", 1);
        try_ar("R2 read 2", 1);
        try_ar("R2 read 3 blocked", 0);
        rbeat(0);
        try_ar("R6 non-last beat keeps block", 0);
        rbeat(1);
        try_ar("R6 last beat frees slot", 1);
        rbeat(1);
        rbeat(1);
    endtask

    task automatic t_write_cap();
        set_cfg(6'd0, 6'd1, 6'd0);
        try_aw("R3 write 1", 1);
        try_aw("R3 write 2 blocked", 0);
        try_ar("R3 reads unaffected", 1);
        bresp();
        try_aw("R7 response frees slot", 1);
        bresp();
        rbeat(1);
    endtask

    task automatic t_combined();
        set_cfg(6'd0, 6'd0, 6'd2);
        try_ar("R4 read", 1);
        try_aw("R4 write", 1);
        try_ar("R4 read blocked", 0);
        try_aw("R4 write blocked", 0);
        bresp();
        try_ar("R4 read after retire", 1);
        rbeat(1);
        rbeat(1);
    endtask

    task automatic t_unlimited();
        set_cfg(6'd0, 6'd0, 6'd0);
        for (int i = 0; i < 40; i++) try_ar("R5 unlimited read", 1);
        for (int i = 0; i < 40; i++) rbeat(1);
        try_aw("R5 write after drain", 1);
        bresp();
    endtask

    task automatic t_priority();
        set_cfg(6'd0, 6'd0, 6'd1);
        @(negedge clk);
        s_arvalid = 1; m_arready = 1; s_awvalid = 1; m_awready = 1;
        #1;
        chk("R9 read wins last slot", m_arvalid, 1);
        chk("R9 write waits", m_awvalid, 0);
        @(posedge clk); #1;
        s_arvalid = 0; m_arready = 0;
        rbeat(1);
        @(negedge clk); #1;
        chk("R9 write goes after retire", m_awvalid, 1);
        @(posedge clk); #1;
        s_awvalid = 0; m_awready = 0;
        bresp();
        // two slots: both go together
        set_cfg(6'd0, 6'd0, 6'd2);
        @(negedge clk);
        s_arvalid = 1; m_arready = 1; s_awvalid = 1; m_awready = 1;
        #1;
        chk("R9 both with two slots", {m_arvalid, m_awvalid}, 2'b11);
        @(posedge clk); #1;
        s_arvalid = 0; m_arready = 0; s_awvalid = 0; m_awready = 0;
        rbeat(1);
        bresp();
    endtask

    task automatic t_hold();
        set_cfg(6'd0, 6'd0, 6'd1);
        @(negedge clk);
        s_arvalid = 1; m_arready = 0; s_awvalid = 1; m_awready = 1;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R8 read stays offered", m_arvalid, 1);
            chk("R8 waiting read keeps slot", m_awvalid, 0);
            @(negedge clk);
        end
        m_arready = 1;
        #1;
        chk("R8 read accepted", s_arready, 1);
        @(posedge clk); #1;
        s_arvalid = 0; m_arready = 0;
        @(negedge clk); #1;
        chk("R4 write blocked by pending read", m_awvalid, 0);
        rbeat(1);
        @(negedge clk); #1;
        chk("R4 write after read retires", m_awvalid, 1);
        @(posedge clk); #1;
        s_awvalid = 0; m_awready = 0;
        bresp();
    endtask

    task automatic t_same_cycle();
        set_cfg(6'd2, 6'd0, 6'd0);
        try_ar("R10 first read", 1);
        @(negedge clk);
        s_arvalid = 1; m_arready = 1; m_rvalid = 1; m_rlast = 1; s_rready = 1;
        #1;
        chk("R10 issue with retire", m_arvalid, 1);
        @(posedge clk); #1;
        s_arvalid = 0; m_arready = 0; m_rvalid = 0; m_rlast = 0; s_rready = 0;
        try_ar("R10 count held, room for one", 1);
        try_ar("R10 now full", 0);
        rbeat(1);
        rbeat(1);
    endtask

    task automatic t_passthrough();
        @(negedge clk);
        m_rvalid = 1; m_rlast = 1; s_rready = 0; m_bvalid = 1; s_bready = 0;
        #1;
        chk("R11 rvalid", s_rvalid, 1);
        chk("R11 rlast", s_rlast, 1);
        chk("R11 rready low", m_rready, 0);
        chk("R11 bvalid", s_bvalid, 1);
        chk("R11 bready low", m_bready, 0);
        m_rvalid = 0; m_rlast = 0; m_bvalid = 0;
        #1;
        chk("R11 rvalid low", s_rvalid, 0);
        chk("R11 bvalid low", s_bvalid, 0);
        @(negedge clk);
        set_cfg(6'd1, 6'd1, 6'd0);
        try_ar("R11 no state change", 1);
        rbeat(1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_read_cap();
        t_write_cap();
        t_combined();
        t_unlimited();
        t_priority();
        t_hold();
        t_same_cycle();
        t_passthrough();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule